// File: doc/BRIEF.md
# Privilege-Gated Timer Register Decoder

This block sits between an instruction pipeline's coprocessor-style register port and the timer hardware. It decodes each access to the timer register space from a register selector: a primary field `selCrm`, two opcode fields `selOpc1` and `selOpc2`, and a flag that marks a 64-bit access. It then decides from the current privilege level whether the access is allowed. Allowed accesses to the two timer channels (physical and virtual) or to the shared counter raise a one-cycle select strobe toward that unit. The strobe carries a register-kind code and, for writes, the write data.

Two registers live inside the block. The first is a frequency register that software can read and write; writing it does not change the real tick rate. The second is a kernel-control register whose bits decide which register groups unprivileged code may read. An access that is unmapped, or that the privilege rules forbid, produces an undefined-instruction flag in place of a data response. Every access receives its response exactly one cycle after the request.

Top module: `timer_access_decoder`

## Requirements
- R1: A 32-bit access (`reqWide`=0) is mapped only when `selOpc1`=0. Within that: `selCrm`=0 with `selOpc2`=0 is the frequency register, and `selCrm`=1 with `selOpc2`=0 is the kernel-control register. `selCrm`=2 is the physical channel and `selCrm`=3 the virtual channel. In a channel, `selOpc2`=1 is the control register (`regKind`=0) and `selOpc2`=0 is the timer-value view (`regKind`=1). A granted channel access pulses `physStb` or `virtStb` in the request cycle.
- R2: For a 64-bit access, `selOpc1` picks the register and `selCrm`/`selOpc2` are ignored. 0 is the physical count and 1 the virtual count; both pulse `cntStb` with `regKind`=3, and `cntVirt` is 0 for physical and 1 for virtual. 2 is the physical compare value and 3 the virtual compare value; these pulse the channel strobe with `regKind`=2. Any `selOpc1` above 3 is unmapped.
- R3: At privilege 0 the physical count is readable only when kernel-control bit 0 is set, and the virtual count only when bit 1 is set.
- R4: At privilege 0, every physical-channel register (control, timer value, compare value) is readable only when kernel-control bit 9 is set; the virtual channel needs bit 8.
- R5: At privilege 0 the frequency register is readable only when kernel-control bit 0 or bit 1 is set.
- R6: The kernel-control register resets to 0. It is readable and writable only at privilege 1, and reads back the 32 bits last written.
- R7: No write is allowed at privilege 0. Count writes are refused at both levels. A refused write pulses no strobe and raises no `extWrite`.
- R8: The frequency register resets to 62,500,000. At privilege 1 it reads back the last value written to it (the low 32 bits of `wrData`).
- R9: A refused or unmapped access raises `rspUndef` together with `rspValid` for one cycle. It returns zero data, pulses no strobe and changes no stored register.
- R10: `rspValid` is high exactly in the cycle after each request. A granted read returns data zero-extended to 64 bits: the frequency or kernel-control value, or else the `extRdData` present in the request cycle. A granted write returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 64-bit access |
| selCrm | input | 4 | Primary register selector |
| selOpc1 | input | 4 | First opcode selector |
| selOpc2 | input | 3 | Second opcode selector |
| privLevel | input | 1 | Current privilege (0 unprivileged, 1 privileged) |
| wrData | input | 64 | Write data |
| extRdData | input | 64 | Read data returned by the selected channel or counter in the request cycle |
| physStb | output | 1 | Physical channel select strobe |
| virtStb | output | 1 | Virtual channel select strobe |
| cntStb | output | 1 | Counter select strobe |
| cntVirt | output | 1 | Counter view: 0 physical, 1 virtual |
| regKind | output | 2 | 0 control, 1 timer value, 2 compare value, 3 count |
| extWrite | output | 1 | Strobe is a write |
| extWrData | output | 64 | Write data toward channels |
| rspValid | output | 1 | Response valid |
| rspUndef | output | 1 | Undefined-instruction indication |
| rspData | output | 64 | Read data |

## Verification
The assertions assume a single 0/1 privilege input and requests that are plain level pulses. They do not require `extRdData` to hold a meaningful value outside granted reads. The stimulus drives every field at the falling edge and holds it for a full cycle. Random selector values are drawn slightly past the mapped range, so that unmapped codes occur, and random kernel-control values are written often enough to visit every combination of gate bits at privilege 0.

// File: rtl/timer_dec_pkg.sv
package timer_dec_pkg;

  typedef enum logic [1:0] {
    KIND_CTL  = 2'd0,
    KIND_TVAL = 2'd1,
    KIND_CVAL = 2'd2,
    KIND_CNT  = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_FREQ, TGT_KCTL,
    TGT_PCTL, TGT_PTVAL, TGT_VCTL, TGT_VTVAL,
    TGT_PCNT, TGT_VCNT, TGT_PCVAL, TGT_VCVAL
  } target_e;

  // strobes from control to datapath
  typedef struct packed {
    logic req;
    logic grant;
    logic wr;
    logic selFreq;
    logic selKctl;
    logic selPhys;
    logic selVirt;
    logic selCnt;
  } stb_t;

  // kernel-control gate bits handed from datapath to control
  typedef struct packed {
    logic physTmr;
    logic virtTmr;
    logic physCnt;
    logic virtCnt;
  } gate_t;

endpackage

// File: rtl/timer_dec_ctrl.sv
module timer_dec_ctrl
  import timer_dec_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int OPC2_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [SEL_W-1:0]  selCrm,
  input  logic [SEL_W-1:0]  selOpc1,
  input  logic [OPC2_W-1:0] selOpc2,
  input  logic              privLevel,
  input  gate_t             gates,
  output stb_t              stb,
  output logic              cntVirt,
  output kind_e             kind
);

  target_e tgt;
  logic    allowed;

  always_comb begin
    tgt = TGT_NONE;
    if (reqWide) begin
      case (selOpc1)
        SEL_W'(0): tgt = TGT_PCNT;
        SEL_W'(1): tgt = TGT_VCNT;
        SEL_W'(2): tgt = TGT_PCVAL;
        SEL_W'(3): tgt = TGT_VCVAL;
        default:   tgt = TGT_NONE;
      endcase
    end else if (selOpc1 == '0) begin
      case (selCrm)
        SEL_W'(0): if (selOpc2 == '0) tgt = TGT_FREQ;
        SEL_W'(1): if (selOpc2 == '0) tgt = TGT_KCTL;
        SEL_W'(2): begin
          if (selOpc2 == OPC2_W'(1)) tgt = TGT_PCTL;
          else if (selOpc2 == '0)    tgt = TGT_PTVAL;
        end
        SEL_W'(3): begin
          if (selOpc2 == OPC2_W'(1)) tgt = TGT_VCTL;
          else if (selOpc2 == '0)    tgt = TGT_VTVAL;
        end
        default: tgt = TGT_NONE;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      TGT_FREQ:  allowed = privLevel || (!reqWrite && (gates.physCnt || gates.virtCnt));
      TGT_KCTL:  allowed = privLevel;
      TGT_PCTL, TGT_PTVAL, TGT_PCVAL:
                 allowed = privLevel || (!reqWrite && gates.physTmr);
      TGT_VCTL, TGT_VTVAL, TGT_VCVAL:
                 allowed = privLevel || (!reqWrite && gates.virtTmr);
      TGT_PCNT:  allowed = !reqWrite && (privLevel || gates.physCnt);
      TGT_VCNT:  allowed = !reqWrite && (privLevel || gates.virtCnt);
      default:   allowed = 1'b0;
    endcase
  end

  logic ok;
  assign ok = reqValid && allowed;

  always_comb begin
    stb.req     = reqValid;
    stb.grant   = ok;
    stb.wr      = reqWrite;
    stb.selFreq = ok && (tgt == TGT_FREQ);
    stb.selKctl = ok && (tgt == TGT_KCTL);
    stb.selPhys = ok && (tgt inside {TGT_PCTL, TGT_PTVAL, TGT_PCVAL});
    stb.selVirt = ok && (tgt inside {TGT_VCTL, TGT_VTVAL, TGT_VCVAL});
    stb.selCnt  = ok && (tgt inside {TGT_PCNT, TGT_VCNT});
    cntVirt     = (tgt == TGT_VCNT);
    case (tgt)
      TGT_PTVAL, TGT_VTVAL: kind = KIND_TVAL;
      TGT_PCVAL, TGT_VCVAL: kind = KIND_CVAL;
      TGT_PCNT, TGT_VCNT:   kind = KIND_CNT;
      default:              kind = KIND_CTL;
    endcase
  end

  // R7: unprivileged writes never granted
  assert_no_user_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !privLevel) |-> !stb.grant);

  // R3: counter strobe at privilege 0 needs its gate bit
  assert_cnt_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.selCnt && !privLevel) |-> (cntVirt ? gates.virtCnt : gates.physCnt));

  // R4: channel strobes at privilege 0 need their gate bits
  assert_chan_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!privLevel && (stb.selPhys || stb.selVirt)) |->
      (stb.selPhys ? gates.physTmr : gates.virtTmr));

  // R9: at most one target selected
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.selFreq, stb.selKctl, stb.selPhys, stb.selVirt, stb.selCnt}));

endmodule

// File: rtl/timer_dec_dpath.sv
module timer_dec_dpath
  import timer_dec_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int REG_W       = 32,
  parameter int FREQ_RESET  = 62500000,
  parameter int PCT_BIT     = 0,
  parameter int VCT_BIT     = 1,
  parameter int VTMR_BIT    = 8,
  parameter int PTMR_BIT    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [REG_W-1:0]  wrLow,
  input  logic [DATA_W-1:0] extRdData,
  output gate_t             gates,
  output logic              rspValid,
  output logic              rspUndef,
  output logic [DATA_W-1:0] rspData
);

  localparam int PAD_W = DATA_W - REG_W;
  localparam logic [REG_W-1:0] FREQ_INIT = REG_W'(FREQ_RESET);

  logic [REG_W-1:0]  freqQ;
  logic [REG_W-1:0]  kctlQ;
  logic [DATA_W-1:0] rdMux;

  assign gates.physTmr = kctlQ[PTMR_BIT];
  assign gates.virtTmr = kctlQ[VTMR_BIT];
  assign gates.physCnt = kctlQ[PCT_BIT];
  assign gates.virtCnt = kctlQ[VCT_BIT];

  always_comb begin
    rdMux = '0;
    if (stb.wr)                                     rdMux = '0;
    else if (stb.selFreq)                           rdMux = {{PAD_W{1'b0}}, freqQ};
    else if (stb.selKctl)                           rdMux = {{PAD_W{1'b0}}, kctlQ};
    else if (stb.selPhys || stb.selVirt || stb.selCnt) rdMux = extRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqQ    <= FREQ_INIT;
      kctlQ    <= '0;
      rspValid <= 1'b0;
      rspUndef <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= stb.req;
      rspUndef <= stb.req && !stb.grant;
      rspData  <= stb.req ? rdMux : '0;
      if (stb.wr && stb.selFreq) freqQ <= wrLow;
      if (stb.wr && stb.selKctl) kctlQ <= wrLow;
    end
  end

  // R10: response exactly one cycle after each request
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.req |=> rspValid);
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.req |=> !rspValid);

  // R9: undefined responses carry no data
  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspUndef |-> (rspValid && rspData == '0));

  // R6: kernel-control changes only on a granted write to it
  assert_kctl_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.selKctl) |=> $stable(kctlQ));

  // R8: frequency changes only on a granted write to it
  assert_freq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.selFreq) |=> $stable(freqQ));

endmodule

// File: rtl/timer_access_decoder.sv
module timer_access_decoder
  import timer_dec_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int REG_W      = 32,
  parameter int SEL_W      = 4,
  parameter int OPC2_W     = 3,
  parameter int FREQ_RESET = 62500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [SEL_W-1:0]  selCrm,
  input  logic [SEL_W-1:0]  selOpc1,
  input  logic [OPC2_W-1:0] selOpc2,
  input  logic              privLevel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] extRdData,
  output logic              physStb,
  output logic              virtStb,
  output logic              cntStb,
  output logic              cntVirt,
  output logic [1:0]        regKind,
  output logic              extWrite,
  output logic [DATA_W-1:0] extWrData,
  output logic              rspValid,
  output logic              rspUndef,
  output logic [DATA_W-1:0] rspData
);

  stb_t  stb;
  gate_t gates;
  kind_e kind;

  timer_dec_ctrl #(.SEL_W(SEL_W), .OPC2_W(OPC2_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .selCrm(selCrm), .selOpc1(selOpc1), .selOpc2(selOpc2),
    .privLevel(privLevel), .gates(gates), .stb(stb), .cntVirt(cntVirt),
    .kind(kind)
  );

  timer_dec_dpath #(.DATA_W(DATA_W), .REG_W(REG_W), .FREQ_RESET(FREQ_RESET)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrLow(wrData[REG_W-1:0]),
    .extRdData(extRdData), .gates(gates), .rspValid(rspValid),
    .rspUndef(rspUndef), .rspData(rspData)
  );

  assign physStb   = stb.selPhys;
  assign virtStb   = stb.selVirt;
  assign cntStb    = stb.selCnt;
  assign regKind   = kind;
  assign extWrite  = stb.wr && (stb.selPhys || stb.selVirt);
  assign extWrData = wrData;

endmodule

// File: tb/tb_timer_access_decoder.sv
`timescale 1ns/1ps
module tb_timer_access_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqWrite = 0, reqWide = 0, privLevel = 0;
  logic [3:0]  selCrm = 0, selOpc1 = 0;
  logic [2:0]  selOpc2 = 0;
  logic [63:0] wrData = 0, extRdData = 0;
  logic        physStb, virtStb, cntStb, cntVirt, extWrite, rspValid, rspUndef;
  logic [1:0]  regKind;
  logic [63:0] extWrData, rspData;

  int total = 0;
  int bad = 0;
  logic [31:0] mFreq = 32'd62500000;
  logic [31:0] mKctl = 32'd0;

  always #4 clk = ~clk;

  timer_access_decoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .selCrm(selCrm), .selOpc1(selOpc1), .selOpc2(selOpc2),
    .privLevel(privLevel), .wrData(wrData), .extRdData(extRdData),
    .physStb(physStb), .virtStb(virtStb), .cntStb(cntStb), .cntVirt(cntVirt),
    .regKind(regKind), .extWrite(extWrite), .extWrData(extWrData),
    .rspValid(rspValid), .rspUndef(rspUndef), .rspData(rspData)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none,1 freq,2 kctl,3 pctl,4 ptval,5 vctl,6 vtval,7 pcnt,8 vcnt,9 pcval,10 vcval
  function automatic int decodeRef(bit wide, int crm, int opc1, int opc2);
    if (wide) return (opc1 <= 3) ? 7 + opc1 : 0;
    if (opc1 != 0) return 0;
    case (crm)
      0: return (opc2 == 0) ? 1 : 0;
      1: return (opc2 == 0) ? 2 : 0;
      2: return (opc2 == 1) ? 3 : ((opc2 == 0) ? 4 : 0);
      3: return (opc2 == 1) ? 5 : ((opc2 == 0) ? 6 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic bit permitRef(int t, bit wr, bit pv, logic [31:0] k);
    case (t)
      1: return pv || (!wr && (k[0] || k[1]));
      2: return pv;
      3, 4, 9: return pv || (!wr && k[9]);
      5, 6, 10: return pv || (!wr && k[8]);
      7: return !wr && (pv || k[0]);
      8: return !wr && (pv || k[1]);
      default: return 0;
    endcase
  endfunction

  function automatic string tagRef(int t, bit wr, bit pv);
    if (wr && !pv && t != 0) return "R7";
    case (t)
      0: return "R9";
      1: return "R5";
      2: return "R6";
      7, 8: return (wr ? "R7" : "R3");
      default: return "R4";
    endcase
  endfunction

  task automatic access(bit wr, bit wide, int crm, int opc1, int opc2, bit pv,
                        logic [63:0] wd);
    int t; bit g; string tg; logic [63:0] ext, expData;
    bit ePhys, eVirt, eCnt;
    int eKind;
    @(negedge clk);
    ext = {$urandom, $urandom};
    reqValid = 1; reqWrite = wr; reqWide = wide; selCrm = 4'(crm);
    selOpc1 = 4'(opc1); selOpc2 = 3'(opc2); privLevel = pv; wrData = wd;
    extRdData = ext;
    t  = decodeRef(wide, crm, opc1, opc2);
    g  = permitRef(t, wr, pv, mKctl);
    tg = tagRef(t, wr, pv);
    ePhys = g && (t == 3 || t == 4 || t == 9);
    eVirt = g && (t == 5 || t == 6 || t == 10);
    eCnt  = g && (t == 7 || t == 8);
    eKind = (t == 4 || t == 6) ? 1 : (t == 9 || t == 10) ? 2 : (t == 7 || t == 8) ? 3 : 0;
    #1;
    check(physStb == ePhys && virtStb == eVirt && cntStb == eCnt,
          wide ? "R2 strobes" : "R1 strobes", {physStb, virtStb, cntStb},
          {ePhys, eVirt, eCnt});
    if (ePhys || eVirt || eCnt)
      check(regKind == 2'(eKind), wide ? "R2 kind" : "R1 kind", regKind, eKind);
    if (eCnt) check(cntVirt == (t == 8), "R2 cntVirt", cntVirt, t == 8);
    check(extWrite == (wr && (ePhys || eVirt)), "R7 extWrite", extWrite,
          wr && (ePhys || eVirt));
    if (!g) expData = 0;
    else if (wr) expData = 0;
    else if (t == 1) expData = {32'd0, mFreq};
    else if (t == 2) expData = {32'd0, mKctl};
    else expData = ext;
    @(negedge clk);
    check(rspValid == 1, "R10 valid", rspValid, 1);
    check(rspUndef == !g, tg, rspUndef, !g);
    check(rspData == expData, (t == 1) ? "R8 data" : "R10 data", rspData, expData);
    if (g && wr && t == 1) mFreq = wd[31:0];
    if (g && wr && t == 2) mKctl = wd[31:0];
    reqValid = 0;
  endtask

  task automatic idleCheck();
    reqValid = 0;
    @(negedge clk);
    @(negedge clk);
    check(rspValid == 0, "R10 idle", rspValid, 0);
  endtask

  initial begin
    #(8 * 190000);
    total++; bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(rspValid == 0 && rspUndef == 0, "R10 reset", {rspValid, rspUndef}, 0);
    // reset values
    access(0, 0, 0, 0, 0, 1, 0);              // R8 freq reset read
    access(0, 0, 1, 0, 0, 1, 0);              // R6 kctl reset read
    // privilege 0 with all gates clear
    access(0, 0, 0, 0, 0, 0, 0);              // R5 freq denied
    access(0, 1, 0, 0, 0, 0, 0);              // R3 pcnt denied
    access(0, 0, 2, 0, 1, 0, 0);              // R4 pctl denied
    access(0, 0, 1, 0, 0, 0, 0);              // R6 kctl denied at priv0
    // R8 priv0 write refused, value kept
    access(1, 0, 0, 0, 0, 0, 64'h1234);
    access(0, 0, 0, 0, 0, 1, 0);
    access(1, 0, 0, 0, 0, 1, 64'hFFFF_0000_0BAD_F00D); // R8 write
    access(0, 0, 0, 0, 0, 1, 0);
    // only virtual count gate: freq readable (R5), pcnt not (R3)
    access(1, 0, 1, 0, 0, 1, 64'h2);
    access(0, 0, 0, 0, 0, 0, 0);
    access(0, 1, 0, 1, 0, 0, 0);
    access(0, 1, 0, 0, 0, 0, 0);
    // only virtual channel gate (bit 8)
    access(1, 0, 1, 0, 0, 1, 64'h100);
    access(0, 1, 0, 3, 0, 0, 0);              // R4 vcval ok
    access(0, 1, 0, 2, 0, 0, 0);              // R4 pcval denied
    access(0, 0, 3, 0, 0, 0, 0);              // vtval ok
    // count writes at priv1 refused (R7), unmapped codes (R9)
    access(1, 1, 0, 0, 0, 1, 64'h55);
    access(1, 1, 0, 1, 0, 1, 64'h55);
    access(0, 1, 0, 4, 0, 1, 0);
    access(0, 0, 2, 0, 2, 1, 0);
    access(0, 0, 2, 1, 1, 1, 0);
    access(1, 0, 3, 0, 1, 1, 64'hABCD);       // R1 vctl write
    idleCheck();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 6) == 0)
        access(1, 0, 1, 0, 0, 1, {32'd0, $urandom});
      else
        access(($urandom % 3) == 0, $urandom % 2, $urandom % 5, $urandom % 5,
               $urandom % 3, $urandom % 2, {$urandom, $urandom});
      if (($urandom % 20) == 0) idleCheck();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule